// File: doc/BRIEF.md
# Pin Event Detector with Interrupt and DMA Request Lines

This block watches a port of up to 32 input pins and records, for each pin, a sticky event flag when the event chosen for that pin occurs. Each pin has a 4-bit event code. The code selects one of three groups. The first is a DMA request on a rising edge, a falling edge or either edge. The second is an interrupt on a rising edge, a falling edge, either edge, a low level or a high level. The third is no detection at all. Pin inputs are synchronized before detection, so any asynchronous source may drive them. Detection does not depend on how the pin is multiplexed elsewhere.

The port drives two request lines. The interrupt line is high while any flag of an interrupt-mode pin is set. The DMA request line is high while any flag of a DMA-mode pin is set. Software programs the codes through a word-addressed register port. Software clears a flag by writing a one to it, either in the pin's own register or in a shared status word. A one-cycle DMA completion pulse clears every set flag that belongs to a DMA-mode pin.

Top module: `pin_event_port`

## Requirements
- R1: After reset every pin code is 0000, every flag is clear, the status word reads 0, and both `irq_o` and `dma_req_o` are low.
- R2: Code 0000, the reserved code 0100 and every code not listed in R3 to R5 never set a flag, whatever the pin does.
- R3: Codes 0001, 0010 and 0011 set the flag on a rising edge, a falling edge and either edge of the pin, and mark the pin as DMA mode. The flag is visible on the third rising clock edge after the pin changes.
- R4: Codes 1001, 1010 and 1011 set the flag on a rising edge, a falling edge and either edge, and mark the pin as interrupt mode.
- R5: Code 1000 sets the flag while the synchronized pin is 0. Code 1100 sets it while the pin is 1. Both are interrupt modes.
- R6: A flag stays set until cleared. Writing 1 to bit 24 of the pin's register, or to bit n of the status word, clears flag n. Writing 0 to either leaves it set.
- R7: In a level mode, if the level is still present when a flag is cleared, the flag reads 0 right after the clearing edge and 1 again one clock later.
- R8: A `dma_done_i` pulse clears the set flags of DMA-mode pins and leaves the flags of interrupt-mode pins untouched.
- R9: `irq_o` is the OR of the flags of interrupt-mode pins. `dma_req_o` is the OR of the flags of DMA-mode pins.
- R10: Word address n (n below NUM_PINS) is pin n's register, with the code in bits 19:16 and the flag in bit 24. Word address NUM_PINS is the status word, with flag n in bit n. All other addresses read 0, and writes to them change nothing.
- R11: An edge detected in the same cycle as a clear write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| dma_done_i | input | 1 | One-cycle pulse: DMA transfer completed |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | $clog2(NUM_PINS)+1 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Port interrupt line |
| dma_req_o | output | 1 | Port DMA request line |

## Verification
The bench builds the block with NUM_PINS = 8 and SYNC_STAGES = 2. This keeps the address space at 16 words, so every unused address can be probed. It also makes a full sweep affordable: every pin runs through all sixteen codes, and each code sees a rising edge, a held high level, a clear under that level, a falling edge and a held low level. For each step the bench works out the expected flag, status word and request lines from the code arithmetically. Separate sequences time a clear write into the same cycle as a detected edge, check that zero writes are ignored, and check that a DMA completion clears DMA-mode flags and leaves interrupt-mode flags set.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int CODE_W       = 4;
  localparam int CFG_CODE_LSB = 16;
  localparam int CFG_FLAG_BIT = 24;

  localparam logic [CODE_W-1:0] EV_OFF      = 4'b0000;
  localparam logic [CODE_W-1:0] EV_DMA_RISE = 4'b0001;
  localparam logic [CODE_W-1:0] EV_DMA_FALL = 4'b0010;
  localparam logic [CODE_W-1:0] EV_DMA_BOTH = 4'b0011;
  localparam logic [CODE_W-1:0] EV_IRQ_LOW  = 4'b1000;
  localparam logic [CODE_W-1:0] EV_IRQ_RISE = 4'b1001;
  localparam logic [CODE_W-1:0] EV_IRQ_FALL = 4'b1010;
  localparam logic [CODE_W-1:0] EV_IRQ_BOTH = 4'b1011;
  localparam logic [CODE_W-1:0] EV_IRQ_HIGH = 4'b1100;

  typedef struct packed {
    logic dma;
    logic irq;
    logic edge_hit;
    logic level_hit;
  } ev_dec_t;

  // Decode a pin code against the current and previous synchronized samples.
  function automatic ev_dec_t ev_decode(logic [CODE_W-1:0] code, logic cur, logic prev);
    ev_dec_t d;
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    d    = '0;
    case (code)
      EV_DMA_RISE: begin d.dma = 1'b1; d.edge_hit  = rise;        end
      EV_DMA_FALL: begin d.dma = 1'b1; d.edge_hit  = fall;        end
      EV_DMA_BOTH: begin d.dma = 1'b1; d.edge_hit  = rise | fall; end
      EV_IRQ_RISE: begin d.irq = 1'b1; d.edge_hit  = rise;        end
      EV_IRQ_FALL: begin d.irq = 1'b1; d.edge_hit  = fall;        end
      EV_IRQ_BOTH: begin d.irq = 1'b1; d.edge_hit  = rise | fall; end
      EV_IRQ_LOW:  begin d.irq = 1'b1; d.level_hit = ~cur;        end
      EV_IRQ_HIGH: begin d.irq = 1'b1; d.level_hit = cur;         end
      default:     d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              clr,
  input  logic              dma_done,
  output logic [CODE_W-1:0] cfg_o,
  output logic              flag_o,
  output logic              irq_mode_o,
  output logic              dma_mode_o
);

  logic              prev_q;
  logic [CODE_W-1:0] cfg_q, cfg_d;
  logic              flag_q, flag_d;
  ev_dec_t           dec;

  always_comb begin
    dec   = ev_decode(cfg_q, pin_s, prev_q);
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_wdata;
    flag_d = flag_q;
    // A clear or a DMA completion drops the flag; a held level sets it again
    // only in a cycle without a clear, while an edge always wins.
    if (clr || (dma_done && dec.dma)) flag_d = 1'b0;
    if (dec.level_hit && !clr)        flag_d = 1'b1;
    if (dec.edge_hit)                 flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cfg_q  <= EV_OFF;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
      if (cfg_we) cfg_q <= cfg_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign flag_o     = flag_q;
  assign irq_mode_o = dec.irq;
  assign dma_mode_o = dec.dma;

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec.dma && !dec.irq) |=> !$rose(flag_q));

  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !dec.edge_hit) |=> !flag_q);

  p_level_reasserts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.level_hit && !clr) |=> flag_q);

  p_dma_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && dec.dma && !dec.edge_hit) |=> !flag_q);

  p_edge_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec.edge_hit |=> flag_q);

endmodule

// File: rtl/pin_evt_regif.sv
module pin_evt_regif
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                             bus_we,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [31:0]                      bus_wdata,
  input  logic [NUM_PINS-1:0][CODE_W-1:0]  cfg_vec,
  input  logic [NUM_PINS-1:0]              flag_vec,
  output logic [NUM_PINS-1:0]              cfg_we,
  output logic [CODE_W-1:0]                cfg_wdata,
  output logic [NUM_PINS-1:0]              clr_vec,
  output logic [31:0]                      bus_rdata
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

  logic stat_hit;

  always_comb begin
    stat_hit  = (bus_addr == STAT_ADDR);
    cfg_wdata = bus_wdata[CFG_CODE_LSB +: CODE_W];
    bus_rdata = '0;
    if (stat_hit) bus_rdata[NUM_PINS-1:0] = flag_vec;
    for (int i = 0; i < NUM_PINS; i++) begin
      cfg_we[i]  = bus_we && (bus_addr == ADDR_W'(i));
      clr_vec[i] = (cfg_we[i] && bus_wdata[CFG_FLAG_BIT]) ||
                   (bus_we && stat_hit && bus_wdata[i]);
      if (bus_addr == ADDR_W'(i)) begin
        bus_rdata[CFG_CODE_LSB +: CODE_W] = cfg_vec[i];
        bus_rdata[CFG_FLAG_BIT]           = flag_vec[i];
      end
    end
  end

endmodule

// File: rtl/pin_event_port.sv
module pin_event_port
  import pin_evt_pkg::*;
#(
  parameter  int NUM_PINS    = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(NUM_PINS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                dma_done_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                irq_o,
  output logic                dma_req_o
);

  logic                            rst_sync_n;
  logic [NUM_PINS-1:0]             pins_s;
  logic [NUM_PINS-1:0][CODE_W-1:0] cfg_vec;
  logic [NUM_PINS-1:0]             flag_vec;
  logic [NUM_PINS-1:0]             irq_mode_vec;
  logic [NUM_PINS-1:0]             dma_mode_vec;
  logic [NUM_PINS-1:0]             cfg_we;
  logic [NUM_PINS-1:0]             clr_vec;
  logic [CODE_W-1:0]               cfg_wdata;

  // Reset: asserted asynchronously, released through a two-stage chain.
  pin_sync #(.WIDTH(1), .STAGES(2)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_evt_cell i_cell (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .pin_s      (pins_s[p]),
      .cfg_we     (cfg_we[p]),
      .cfg_wdata  (cfg_wdata),
      .clr        (clr_vec[p]),
      .dma_done   (dma_done_i),
      .cfg_o      (cfg_vec[p]),
      .flag_o     (flag_vec[p]),
      .irq_mode_o (irq_mode_vec[p]),
      .dma_mode_o (dma_mode_vec[p])
    );
  end

  pin_evt_regif #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_regif (
    .bus_we    (bus_we_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .cfg_vec   (cfg_vec),
    .flag_vec  (flag_vec),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .clr_vec   (clr_vec),
    .bus_rdata (bus_rdata_o)
  );

  always_comb begin
    irq_o     = |(flag_vec & irq_mode_vec);
    dma_req_o = |(flag_vec & dma_mode_vec);
  end

  p_req_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o || dma_req_o) |-> (flag_vec != '0));

  p_modes_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_mode_vec & dma_mode_vec) == '0);

endmodule

// File: tb/test_pin_event_port.sv
module test_pin_event_port;

  localparam int NP   = 8;
  localparam int AW   = $clog2(NP) + 1;
  localparam int STAT = NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          dma_done = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, dreq;

  int n_checks = 0;
  int n_err    = 0;

  always #5 clk = ~clk;

  pin_event_port #(.NUM_PINS(NP), .SYNC_STAGES(2)) i_pin_event_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .dma_done_i  (dma_done),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .dma_req_o   (dreq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  function automatic bit c_rise(int c); return c == 1 || c == 3 || c == 9 || c == 11; endfunction
  function automatic bit c_fall(int c); return c == 2 || c == 3 || c == 10 || c == 11; endfunction
  function automatic bit c_dma(int c);  return c >= 1 && c <= 3; endfunction
  function automatic bit c_irq(int c);  return c >= 8 && c <= 12; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit pre, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1: reset state
    rd(STAT, d); check("R1 status after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 dma_req after reset", {31'b0, dreq}, 32'h0);
    for (int p = 0; p < NP; p++) begin
      rd(p, d); check("R1 pin register after reset", d, 32'h0);
    end

    // R2..R7, R9, R10: every code on every pin
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 16; c++) begin
        wr(p, (32'(c) << 16) | (32'h1 << 24));
        @(posedge clk); #1;
        pre = (c == 8);
        rd(STAT, d); check("R5 R2 flag before edges", d, 32'(pre) << p);
        rd(p, d);    check("R10 pin register layout", d, (32'(c) << 16) | (32'(pre) << 24));

        @(negedge clk); pins = NP'(1) << p;
        repeat (3) @(posedge clk); #1;
        f = pre | c_rise(c) | (c == 12);
        rd(STAT, d); check("R3 R4 R5 R2 flag after rise", d, 32'(f) << p);
        check("R9 irq after rise", {31'b0, irq}, {31'b0, f & c_irq(c)});
        check("R9 dma_req after rise", {31'b0, dreq}, {31'b0, f & c_dma(c)});

        wr(STAT, 32'h1 << p);
        rd(STAT, d); check("R6 R7 flag right after clear", d, 32'h0);
        @(posedge clk); #1;
        rd(STAT, d); check("R7 flag one cycle after clear", d, 32'(c == 12) << p);

        @(negedge clk); pins = '0;
        repeat (3) @(posedge clk); #1;
        f = (c == 12) | c_fall(c) | (c == 8);
        rd(STAT, d); check("R3 R4 R5 R2 flag after fall", d, 32'(f) << p);
        check("R9 irq after fall", {31'b0, irq}, {31'b0, f & c_irq(c)});
        check("R9 dma_req after fall", {31'b0, dreq}, {31'b0, f & c_dma(c)});

        wr(p, 32'h1 << 24);
        rd(STAT, d); check("R6 clear via pin register", d, 32'h0);
      end
    end

    // R6: zero writes leave a set flag alone
    wr(3, 32'hB << 16);
    @(negedge clk); pins = 8'h08;
    repeat (3) @(posedge clk); #1;
    rd(STAT, d); check("R4 both-edge flag set", d, 32'h08);
    wr(STAT, 32'h0);
    rd(STAT, d); check("R6 zero to status ignored", d, 32'h08);
    wr(3, 32'hB << 16);
    rd(STAT, d); check("R6 zero flag bit ignored", d, 32'h08);
    wr(3, (32'hB << 16) | (32'h1 << 24));
    rd(STAT, d); check("R6 one to flag bit clears", d, 32'h0);
    wr(3, 32'h1 << 24);
    @(negedge clk); pins = '0;
    repeat (3) @(posedge clk); #1;

    // R11: clear write in the same cycle as a detected edge
    wr(2, 32'h9 << 16);
    @(negedge clk); pins = 8'h04;
    repeat (2) @(posedge clk);
    wr(STAT, 32'h04);
    rd(STAT, d); check("R11 edge wins over clear", d, 32'h04);
    wr(2, 32'h1 << 24);
    @(negedge clk); pins = '0;
    repeat (3) @(posedge clk); #1;

    // R8: DMA completion clears DMA-mode flags only
    wr(0, 32'h1 << 16);
    wr(1, 32'h9 << 16);
    @(negedge clk); pins = 8'h03;
    repeat (3) @(posedge clk); #1;
    rd(STAT, d); check("R8 both flags set", d, 32'h03);
    check("R9 irq with irq flag", {31'b0, irq}, 32'h1);
    check("R9 dma_req with dma flag", {31'b0, dreq}, 32'h1);
    @(negedge clk); dma_done = 1'b1;
    @(posedge clk); #1; dma_done = 1'b0;
    rd(STAT, d); check("R8 dma flag cleared, irq flag kept", d, 32'h02);
    check("R8 dma_req low after done", {31'b0, dreq}, 32'h0);
    check("R8 irq still high after done", {31'b0, irq}, 32'h1);
    @(posedge clk); #1;
    rd(STAT, d); check("R8 state stable after done", d, 32'h02);
    wr(0, 32'h1 << 24);
    wr(1, 32'h1 << 24);
    @(negedge clk); pins = '0;
    repeat (3) @(posedge clk); #1;

    // R10: unused addresses read zero and ignore writes
    for (int a = NP + 1; a < (1 << AW); a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a, d); check("R10 unused address reads zero", d, 32'h0);
    end
    for (int p = 0; p < NP; p++) begin
      rd(p, d); check("R10 pin registers untouched", d, 32'h0);
    end
    rd(STAT, d); check("R10 status untouched", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule